// File: doc/BRIEF.md
# Flag-Compare Arithmetic Logic Unit

This block is the arithmetic and logic engine of a simple single-cycle processor datapath. It takes two operands, `a` and `b`, and a 5-bit function code. It returns one result word and a zero flag. Inside, three units work side by side: an adder that can also subtract, a Boolean unit and a barrel shifter that shifts in both directions. A mux picks which unit drives the result. Comparisons have no comparator of their own. They come from the sign, overflow and carry flags of the subtraction `a - b`.

The function code holds three one-hot class bits: math, shift and Boolean. It also holds a modifier bit that means subtract or arithmetic, and one op bit. Bit positions from MSB to LSB are: `fn[4]` modifier, `fn[3]` Boolean class, `fn[2]` shift class, `fn[1]` math class, `fn[0]` op. The result and the zero flag are registered, so an operation presented before a rising clock edge appears at the outputs just after that edge.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the registers load `result` = 0 and `zero` = 1.
- R2: Outputs change only at a rising edge. They show the function of the inputs sampled at that edge, which is a latency of one cycle.
- R3: Code 0x02 gives `a + b` and code 0x12 gives `a - b`, both modulo 2^WIDTH. Subtraction is computed as `a + ~b + 1`.
- R4: Code 0x13 gives the signed less-than as 0 or 1 in bit 0, with all other bits 0. It equals N XOR V of `a - b`, so it stays correct when the subtraction overflows.
- R5: Code 0x03 gives the unsigned less-than as 0 or 1 in bit 0, with all other bits 0. It equals the inverse of the carry out of `a + ~b + 1`.
- R6: Code 0x08 gives `a & b`, code 0x09 gives `a | b`, and codes 0x18 and 0x19 give `a ^ b`.
- R7: Codes 0x04 and 0x14 shift `b` left logically, and code 0x05 shifts `b` right logically. The shift amount is the low log2(WIDTH) bits of `a`, and the upper bits of `a` are ignored.
- R8: Code 0x15 shifts `b` right arithmetically and fills the vacated bits with `b`'s sign bit.
- R9: `zero` is 1 exactly when the registered `result` is all zeros. After a subtraction of equal operands it is therefore 1.
- R10: A code whose class bits `fn[3:1]` are not exactly one-hot gives `result` = 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fn | input | 5 | Function code: modifier, Boolean, shift, math, op |
| a | input | WIDTH | First operand; its low bits are the shift amount |
| b | input | WIDTH | Second operand; the value that is shifted |
| result | output | WIDTH | Registered result |
| zero | output | 1 | Registered flag, high when result is zero |

## Verification
The bench targets the pairs where signed and unsigned order disagree, and the subtractions that overflow, such as the most negative value against 1. A design that took the sign of the difference in place of N XOR V would invert the signed compare there. A design that used the carry directly would invert every unsigned compare. Shifts by 0, by 31 and by amounts whose upper bits of `a` are set show whether the amount is truncated and whether the arithmetic shift fills with the sign. Illegal class combinations and equal-operand subtraction check that a bad code yields zero and that the zero flag follows the result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Layout of the function code, MSB first; the bench relies on this order.
  typedef struct packed {
    logic modf;   // subtract / arithmetic modifier
    logic cl_bool;
    logic cl_shft;
    logic cl_math;
    logic op;
  } alu_fn_t;

  localparam int FN_W = $bits(alu_fn_t);
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             lt_signed,
  output logic             lt_unsigned
);
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH:0]   wide;
  logic             flag_n, flag_v, flag_c;

  always_comb begin
    y_eff  = y ^ {WIDTH{do_sub}};
    wide   = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, do_sub};
    sum    = wide[WIDTH-1:0];
    flag_c = wide[WIDTH];
    flag_n = sum[WIDTH-1];
    flag_v = (x[WIDTH-1] == y_eff[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);
    lt_signed   = flag_n ^ flag_v;
    lt_unsigned = ~flag_c;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    unique case (sel)
      2'b00:   out = x & y;
      2'b01:   out = x | y;
      default: out = x ^ y;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  input  logic [SHW-1:0]   amt,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] val_rev;
  logic [WIDTH-1:0] last_rev;
  logic [WIDTH-1:0] stage [0:SHW];
  logic             fill;

  assign fill = arith & ~left & val[WIDTH-1];

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign val_rev[i]  = val[WIDTH-1-i];
    assign last_rev[i] = stage[SHW][WIDTH-1-i];
  end

  assign stage[0] = left ? val_rev : val;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][WIDTH-1:D]} : stage[s];
  end

  assign out = left ? last_rev : stage[SHW];
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [alu_pkg::FN_W-1:0] fn,
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH-1:0]         b,
  output logic [WIDTH-1:0]         result,
  output logic                     zero
);
  import alu_pkg::*;
  localparam int SHW = $clog2(WIDTH);

  alu_fn_t          f;
  logic             class_ok;
  logic [WIDTH-1:0] sum_w, bool_w, shft_w, pick;
  logic             lts_w, ltu_w;

  assign f        = alu_fn_t'(fn);
  assign class_ok = $onehot({f.cl_bool, f.cl_shft, f.cl_math});

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x(a), .y(b), .do_sub(f.modf | f.op),
    .sum(sum_w), .lt_signed(lts_w), .lt_unsigned(ltu_w)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .x(a), .y(b), .sel({f.modf, f.op}), .out(bool_w)
  );

  alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .val(b), .amt(a[SHW-1:0]), .left(~f.op), .arith(f.modf & f.op),
    .out(shft_w)
  );

  always_comb begin
    pick = '0;
    if (class_ok) begin
      if (f.cl_math) begin
        if (!f.op) pick = sum_w;
        else       pick = {{(WIDTH-1){1'b0}}, f.modf ? lts_w : ltu_w};
      end else if (f.cl_shft) begin
        pick = shft_w;
      end else begin
        pick = bool_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= pick;
      zero   <= (pick == '0);
    end
  end

  // Observation registers for the checks below.
  logic cmp_q, bad_q, subeq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= 1'b0;
      bad_q   <= 1'b0;
      subeq_q <= 1'b0;
    end else begin
      cmp_q   <= class_ok & f.cl_math & f.op;
      bad_q   <= ~class_ok;
      subeq_q <= class_ok & f.cl_math & ~f.op & f.modf & (a == b);
    end
  end

  p_zero_track_r9: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  p_cmp_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_q |-> (result[WIDTH-1:1] == '0));

  p_bad_class_r10: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> (result == '0));

  p_sub_equal_r3: assert property (@(posedge clk) disable iff (rst)
    subeq_q |-> zero);
endmodule

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   fn  = '0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         zero;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  flag_alu #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .fn(fn), .a(a), .b(b), .result(result), .zero(zero)
  );

  function automatic logic [W-1:0] model(input logic [4:0] c,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    logic [4:0] sh;
    sh = x[4:0];
    case (c)
      5'h02: return x + y;
      5'h12: return x - y;
      5'h13: return ($signed(x) < $signed(y)) ? 1 : 0;
      5'h03: return (x < y) ? 1 : 0;
      5'h08: return x & y;
      5'h09: return x | y;
      5'h18, 5'h19: return x ^ y;
      5'h04, 5'h14: return y << sh;
      5'h05: return y >> sh;
      5'h15: return $unsigned($signed(y) >>> sh);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [4:0] c,
                     input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] e;
    @(negedge clk);
    fn = c; a = x; b = y;
    e = model(c, x, y);
    @(negedge clk);
    check(tag, result, e);
    check({tag, " R9 zero"}, {31'd0, zero}, {31'd0, e == '0});
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1 result", result, '0);
    check("R1 zero", {31'd0, zero}, 32'd1);
    rst = 1'b0;
  endtask

  task automatic test_latency;
    run("R2 setup", 5'h02, 32'd5, 32'd6);
    fn = 5'h08; a = 32'hF0F0_0000; b = 32'hFFFF_0000;
    #1;
    check("R2 hold before edge", result, 32'd11);
    @(negedge clk);
    check("R2 after edge", result, 32'hF0F0_0000);
  endtask

  task automatic test_addsub;
    run("R3 add", 5'h02, 32'h1234_5678, 32'h1111_1111);
    run("R3 add wrap", 5'h02, 32'hFFFF_FFFF, 32'd1);
    run("R3 sub", 5'h12, 32'd100, 32'd42);
    run("R3 sub borrow", 5'h12, 32'd0, 32'd1);
    run("R3 R9 sub equal", 5'h12, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
  endtask

  task automatic test_slt;
    run("R4 neg<pos", 5'h13, 32'hFFFF_FFFF, 32'd1);
    run("R4 pos<neg", 5'h13, 32'd1, 32'hFFFF_FFFF);
    run("R4 overflow min<1", 5'h13, 32'h8000_0000, 32'd1);
    run("R4 overflow max<-1", 5'h13, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R4 equal", 5'h13, 32'd7, 32'd7);
  endtask

  task automatic test_sltu;
    run("R5 big<small", 5'h03, 32'hFFFF_FFFF, 32'd1);
    run("R5 small<big", 5'h03, 32'd1, 32'hFFFF_FFFF);
    run("R5 zero<one", 5'h03, 32'd0, 32'd1);
    run("R5 equal", 5'h03, 32'd9, 32'd9);
  endtask

  task automatic test_bool;
    run("R6 and", 5'h08, 32'hFF00_FF00, 32'h0F0F_0F0F);
    run("R6 or", 5'h09, 32'hFF00_0000, 32'h0000_00FF);
    run("R6 xor", 5'h18, 32'hAAAA_5555, 32'hFFFF_0000);
    run("R6 xor alt", 5'h19, 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic test_shift;
    run("R7 sll", 5'h04, 32'd4, 32'h0000_00F1);
    run("R7 sll alt", 5'h14, 32'd31, 32'd3);
    run("R7 srl", 5'h05, 32'd8, 32'h8000_1234);
    run("R7 srl zero amt", 5'h05, 32'd0, 32'hCAFE_F00D);
    run("R7 amt upper bits ignored", 5'h05, 32'hFFFF_FFE3, 32'h8000_0000);
  endtask

  task automatic test_sra;
    run("R8 sra negative", 5'h15, 32'd4, 32'h8000_0000);
    run("R8 sra by 31", 5'h15, 32'd31, 32'h9000_0001);
    run("R8 sra positive", 5'h15, 32'd3, 32'h7000_0000);
  endtask

  task automatic test_bad_class;
    run("R10 no class", 5'h01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R10 two classes", 5'h0A, 32'h1234_5678, 32'hFFFF_FFFF);
    run("R10 all classes", 5'h1F, 32'hFFFF_FFFF, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset;
    test_latency;
    test_addsub;
    test_slt;
    test_sltu;
    test_bool;
    test_shift;
    test_sra;
    test_bad_class;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule